// File: doc/BRIEF.md
# Calibration-Character Bit-Rate Detector

This block works out the bit rate of a serial line from a single calibration character and produces the divider value that a receiver's bit-rate generator needs. The divider relates to the bit time as bit_rate = clock / ((divider + 1) * 8). The calibration character is an uppercase or lowercase letter A (0x41 or 0x61). Both are sent least-significant bit first, so each starts with a low start bit followed by a high first data bit. Each of these two bits lasts exactly one bit time.

Software drives the block through a handshake. It raises the enable input, which reloads the divider with its small primed value of 1. It then pulses the clear strobe so that the done flag starts low. The detector times the low start bit in clock cycles. It checks that the following high bit has a width that agrees with it. It then locks divider = floor(low_cycles / 8) - 1 and raises the done flag. The flag stays high until software clears it. Software then drops the enable, and the locked divider stays on the output for the receiver to use. The receive line must already be synchronised to the block clock.

Top module: `autobaud_rate_detect`

## Requirements
- R1: After a reset, the divider output reads 1 and done reads 0.
- R2: One clock after the enable input goes from 0 to 1, the divider reads 1. It keeps that value while detection is armed (enable high, done low) until a lock occurs.
- R3: Measurement starts when the line is seen high in one clock and low in the next. The low width L is the number of clocks the line then stays low. When a lock occurs, the divider becomes floor(L/8) - 1.
- R4: Detection locks only if the width H of the high bit that follows satisfies |H - L| <= floor(L/8). The lock takes effect on the clock that first sees the line low again. If H is outside that window, no lock occurs.
- R5: When a high bit is rejected, the falling edge that ends it starts a new low-width measurement. No action from software is needed for this.
- R6: A low width L below 8 never produces a lock.
- R7: The done flag rises in the same clock as the divider update. It stays high until the clear strobe is applied. While done is high, line activity changes neither the divider nor done.
- R8: A clear strobe drives done to 0 on the next clock. If a lock happens in the same clock as the strobe, the lock wins and done stays 1.
- R9: While enable is low, line activity changes neither the divider nor done.
- R10: A whole calibration character, 'A' or 'a', sent at T clocks per bit with T a multiple of 8, locks the divider to T/8 - 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Receive line, already synchronised to clk, idle high |
| cal_en | input | 1 | Detection enable; a 0 to 1 change reloads the primed divider |
| done_clr | input | 1 | Single-clock strobe that clears the done flag |
| divider | output | DIV_W (16) | Bit-rate divider, primed to 1 and then locked |
| done | output | 1 | Set on lock, held until cleared |

## Verification
The main function is driven with pairs of a low width and a high width. Some pairs match exactly. Some sit on each edge of the ±L/8 window, one step inside and one step outside, so that the tolerance comparison and its rounding can be told apart. Widths of 7, 8 and 15 separate the too-short rule from the truncation in the divider formula. A large width checks that the counters do not wrap. Whole 'A' and 'a' characters confirm that the later data bits cause no second measurement. A rejected pulse followed directly by a good one shows whether the block rearms on its own. Directed sequences check the enable reload, that done ignores the line once set, the clear strobe, and a lock that lands in the same clock as the clear.

// File: rtl/ab_pkg.sv
// Shared types for the bit-rate detector.
// Assumes: nothing beyond the standard language.
package ab_pkg;
    // Phase of the width measurement.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } ab_phase_e;
endpackage

// File: rtl/ab_edge_timer.sv
// Measures the width of a low pulse and of the high pulse that follows it.
// It raises cand for one clock when the falling edge that ends the high
// pulse is seen. A candidate falling edge always opens a new low
// measurement, which gives rearm-on-reject for free.
// Assumes: rx is synchronous to clk; armed low forces idle.
module ab_edge_timer #(
    parameter int CNT_W = 20,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    input  logic             armed,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len,
    output logic             cand
);
    import ab_pkg::*;

    // Beyond this count, the divider would not fit in DIV_W bits.
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'((1 << (DIV_W + 3)) + 7);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    ab_phase_e        phase;
    logic [CNT_W-1:0] cnt;
    logic             rx_prev;

    // Remember the line level of the previous clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx;
    end

    // Phase machine and width counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            low_len <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (rx_prev && !rx) begin
                        phase <= PH_LOW;
                        cnt   <= ONE;
                    end
                end
                PH_LOW: begin
                    if (rx) begin
                        low_len <= cnt;
                        cnt     <= ONE;
                        phase   <= PH_HIGH;
                    end else if (cnt == CNT_MAX) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_HIGH: begin
                    if (!rx) begin
                        cnt   <= ONE;
                        phase <= PH_LOW;
                    end else if (cnt == CNT_MAX) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign high_len = cnt;
    assign cand     = armed && (phase == PH_HIGH) && !rx;
endmodule

// File: rtl/ab_width_check.sv
// Compares the high width with the low width within +/- low/8, and
// derives the divider floor(low/8) - 1.
// Assumes: low_len never exceeds 2^(DIV_W+3)+7, so floor(low/8)-1 fits.
module ab_width_check #(
    parameter int CNT_W = 20,
    parameter int DIV_W = 16
) (
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    output logic             match,
    output logic [DIV_W-1:0] div_val
);
    logic [CNT_W-1:0] tol;
    logic [CNT_W-1:0] diff;

    // Tolerance, absolute difference and candidate divider.
    always_comb begin
        tol     = low_len >> 3;
        diff    = (high_len >= low_len) ? (high_len - low_len)
                                        : (low_len - high_len);
        match   = (tol != '0) && (diff <= tol);
        div_val = tol[DIV_W-1:0] - DIV_W'(1);
    end
endmodule

// File: rtl/ab_div_reg.sv
// Holds the divider and the done flag. It loads the primed value when the
// enable rises and captures the locked value when a candidate matches.
// Assumes: cand is only raised while armed.
module ab_div_reg #(
    parameter int DIV_W     = 16,
    parameter int PRIME_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_en,
    input  logic             done_clr,
    input  logic             cand,
    input  logic             match,
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] divider,
    output logic             done,
    output logic             lock
);
    localparam logic [DIV_W-1:0] PRIME = DIV_W'(PRIME_VAL);

    logic en_q;

    assign lock = cand && match;

    // Divider: prime on enable rise, capture on lock, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divider <= PRIME;
            en_q    <= 1'b0;
        end else begin
            en_q <= cal_en;
            if (lock)                divider <= div_val;
            else if (cal_en && !en_q) divider <= PRIME;
        end
    end

    // Done flag: lock sets it and takes priority over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b0;
        else if (lock)     done <= 1'b1;
        else if (done_clr) done <= 1'b0;
    end
endmodule

// File: rtl/autobaud_rate_detect.sv
// Top level of the calibration-character bit-rate detector.
// Assumes: rx_line is already synchronised to clk and idles high.
module autobaud_rate_detect #(
    parameter int DIV_W     = 16,
    parameter int PRIME_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic             cal_en,
    input  logic             done_clr,
    output logic [DIV_W-1:0] divider,
    output logic             done
);
    localparam int CNT_W = DIV_W + 4;

    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic             cand;
    logic             match;
    logic [DIV_W-1:0] div_val;
    logic             lock;
    logic             armed;

    assign armed = cal_en && !done;

    ab_edge_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rx(rx_line), .armed(armed),
        .low_len(low_len), .high_len(high_len), .cand(cand)
    );

    ab_width_check #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_check (
        .low_len(low_len), .high_len(high_len),
        .match(match), .div_val(div_val)
    );

    ab_div_reg #(.DIV_W(DIV_W), .PRIME_VAL(PRIME_VAL)) u_div (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .done_clr(done_clr),
        .cand(cand), .match(match), .div_val(div_val),
        .divider(divider), .done(done), .lock(lock)
    );
endmodule

// File: rtl/autobaud_rate_detect_chk.sv
// Property checker for the bit-rate detector, bound to the top module.
// Assumes: lock is the internal one-clock lock pulse.
module autobaud_rate_detect_chk #(
    parameter int DIV_W     = 16,
    parameter int PRIME_VAL = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cal_en,
    input logic             done_clr,
    input logic [DIV_W-1:0] divider,
    input logic             done,
    input logic             lock
);
    logic en_prev;

    // Own copy of the enable from the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= cal_en;
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (divider == DIV_W'(PRIME_VAL)) && !done);

    a_r2_prime_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && !en_prev) |=> (divider == DIV_W'(PRIME_VAL)));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    a_r7_lock_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (cal_en && !done));

    a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !lock) |=> !done);

    a_r8_lock_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> done);

    a_r9_divider_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock && !(cal_en && !en_prev)) |=> $stable(divider));
endmodule

bind autobaud_rate_detect autobaud_rate_detect_chk #(
    .DIV_W(DIV_W), .PRIME_VAL(PRIME_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .done_clr(done_clr),
    .divider(divider), .done(done), .lock(lock)
);

// File: tb/autobaud_rate_detect_tb.sv
// Self-checking bench for the bit-rate detector.
module autobaud_rate_detect_tb;
    localparam int DIV_W = 16;
    localparam int NV    = 10;
    // Stimulus table: low width, high width, lock expected, divider expected.
    localparam int VL [NV] = '{64, 64, 64, 64, 64, 100, 8, 7, 800, 15};
    localparam int VH [NV] = '{64, 72, 73, 55, 56, 100, 8, 7, 790, 16};
    localparam int VK [NV] = '{ 1,  1,  0,  0,  1,   1, 1, 0,   1,  1};
    localparam int VD [NV] = '{ 7,  7,  1,  1,  7,  11, 0, 1,  99,  0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_line = 1'b1;
    logic             cal_en = 1'b0;
    logic             done_clr = 1'b0;
    logic [DIV_W-1:0] divider;
    logic             done;
    int               total = 0;
    int               bad = 0;

    always #2 clk = ~clk;

    autobaud_rate_detect #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .cal_en(cal_en),
        .done_clr(done_clr), .divider(divider), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Low for l clocks, high for h, a short low, then idle high.
    task automatic send_pulse(input int l, input int h);
        rx_line = 1'b0; cycles(l);
        rx_line = 1'b1; cycles(h);
        rx_line = 1'b0; cycles(3);
        rx_line = 1'b1; cycles(20);
    endtask

    // Whole character, least significant bit first, t clocks per bit.
    task automatic send_char(input logic [7:0] ch, input int t);
        rx_line = 1'b0; cycles(t);
        for (int i = 0; i < 8; i++) begin
            rx_line = ch[i]; cycles(t);
        end
        rx_line = 1'b1; cycles(t + 10);
    endtask

    // Disable, clear, re-enable: the software arming sequence.
    task automatic arm();
        cal_en = 1'b0; cycles(1);
        done_clr = 1'b1; cycles(1);
        done_clr = 1'b0; cal_en = 1'b1; cycles(2);
    endtask

    initial begin
        cycles(3);
        check("R1 divider after reset", divider, 1);
        check("R1 done after reset", done, 0);
        rst_n = 1'b1;
        cycles(2);

        for (int v = 0; v < NV; v++) begin
            arm();
            check("R2 primed divider", divider, 1);
            send_pulse(VL[v], VH[v]);
            check("R4 R6 lock result (done)", done, VK[v]);
            check("R3 R4 divider value", divider, VD[v]);
        end

        // R5: a rejected high bit, then a good pulse with no rearming.
        arm();
        rx_line = 1'b0; cycles(64);
        rx_line = 1'b1; cycles(100);
        send_pulse(48, 48);
        check("R5 rearm done", done, 1);
        check("R5 rearm divider", divider, 5);

        // R7: once done is set, line activity is ignored.
        send_pulse(16, 16);
        check("R7 done held", done, 1);
        check("R7 divider held", divider, 5);

        // R8: the clear strobe drops done.
        done_clr = 1'b1; cycles(1);
        done_clr = 1'b0;
        check("R8 done cleared", done, 0);

        // R9: disabled detector ignores the line.
        cal_en = 1'b0; cycles(2);
        send_pulse(64, 64);
        check("R9 done stays low", done, 0);
        check("R9 divider kept", divider, 5);

        // R8: lock and clear in the same clock; lock wins.
        arm();
        rx_line = 1'b0; cycles(64);
        rx_line = 1'b1; cycles(64);
        rx_line = 1'b0; done_clr = 1'b1; cycles(1);
        done_clr = 1'b0; rx_line = 1'b1; cycles(5);
        check("R8 lock beats clear", done, 1);
        check("R8 divider on tie", divider, 7);

        // R10: whole calibration characters.
        arm();
        send_char(8'h61, 40);
        check("R10 lowercase done", done, 1);
        check("R10 lowercase divider", divider, 4);
        arm();
        check("R2 reprime after lock", divider, 1);
        send_char(8'h41, 24);
        check("R10 uppercase done", done, 1);
        check("R10 uppercase divider", divider, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule